// File: doc/BRIEF.md
# Selectable-Clock Base Timer

This block is a free-running 14-bit timekeeping counter. Each cycle of the single clock domain it may advance by one. Whether it advances depends on a selected tick source: a single-cycle strobe derived from a 32.768 kHz crystal, every cycle of the system clock, or the single-cycle prescaler strobe of a general-purpose timer. A fourth source code parks the counter.

Two sticky interrupt flags come out of the counter. The long flag is raised when the counter wraps from its all-ones value back to zero. At the crystal rate that happens every 16384 ticks, or 500 ms. The short flag is raised whenever one software-selected counter bit falls from 1 to 0. The four selectable bits give periods of 32, 128, 512 and 2048 ticks, which is about 976 µs, 3.9 ms, 15.6 ms and 62.5 ms at the crystal rate. Software polls or vectors on the flags and acknowledges each one with its own clear input. A synchronous clear restarts the count and drops both flags.

Top module: `base_tick_timer`

## Requirements
- R1: After reset, `count` is 0 and both `ovf_flag` and `per_flag` are 0.
- R2: When `run_en` is 1 and the selected source fires, `count` increases by one at the next clock edge. Source code 0 uses `xtal_stb`, code 1 advances on every cycle, and code 2 uses `pre_stb`. Strobes of an unselected source have no effect on `count`.
- R3: While `run_en` is 0, `count` holds its value whatever strobes arrive.
- R4: An advance from 16383 makes `count` 0 and sets `ovf_flag` at the same clock edge.
- R5: `per_flag` is set at the edge where an advance makes the tapped counter bit fall from 1 to 0. `tap_sel` codes 0, 1, 2 and 3 select counter bits 4, 6, 8 and 10, which gives periods of 32, 128, 512 and 2048 ticks.
- R6: `clr` set to 1 makes `count`, `ovf_flag` and `per_flag` all 0 at the next edge, and it takes priority over any advance in that cycle.
- R7: `ovf_ack` clears `ovf_flag` and `per_ack` clears `per_flag`. When a set event and the matching acknowledge fall in the same cycle, the flag ends up set.
- R8: Source code 3 never advances `count`.
- R9: A flag that is set stays set until its acknowledge or `clr` arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the block's single domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counting enable |
| clr | input | 1 | Synchronous clear of the count and both flags |
| src_sel | input | 2 | Tick source: 0 crystal strobe, 1 system clock, 2 prescaler strobe, 3 stopped |
| xtal_stb | input | 1 | Single-cycle crystal tick strobe |
| pre_stb | input | 1 | Single-cycle prescaler strobe of the general-purpose timer |
| tap_sel | input | 2 | Short-period tap: 0/1/2/3 select bits 4/6/8/10 |
| ovf_ack | input | 1 | Clear request for the long flag |
| per_ack | input | 1 | Clear request for the short flag |
| count | output | 14 | Current counter value |
| ovf_flag | output | 1 | Long-period (wrap) interrupt flag |
| per_flag | output | 1 | Short-period interrupt flag |

## Verification
The counter is first driven from the system clock through more than one full wrap, and the tap is rotated along the way. This run separates the wrap flag from each of the four short periods and shows whether the right bit is tapped. A mixed run then changes the source at random while the crystal strobe arrives at a fixed rate, the prescaler strobe arrives at random and the enable drops now and then. It tells strobes that count apart from strobes of unselected sources, and it includes the parked code. Directed cases place a clear on an advancing cycle and an acknowledge on the exact wrap cycle, so the priority of clear over advance and of set over acknowledge can each be seen at the ports.

// File: rtl/btm_pkg.sv
package btm_pkg;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_PRE  = 2'd2,
    SRC_OFF  = 2'd3
  } btm_src_e;

  // Counter bit watched by tap code k.
  function automatic int tap_bit(input int k, input int base, input int step);
    return base + step * k;
  endfunction

  // Set-wins-over-acknowledge flag update.
  function automatic logic flag_next(input logic cur, input logic set, input logic ack);
    return set | (cur & ~ack);
  endfunction

endpackage

// File: rtl/btm_src_mux.sv
module btm_src_mux
  import btm_pkg::*;
(
  input  logic       run_en,
  input  logic [1:0] src_sel,
  input  logic       xtal_stb,
  input  logic       pre_stb,
  output logic       adv
);

  logic picked;

  always_comb begin
    case (btm_src_e'(src_sel))
      SRC_XTAL: picked = xtal_stb;
      SRC_SYS:  picked = 1'b1;
      SRC_PRE:  picked = pre_stb;
      default:  picked = 1'b0;
    endcase
  end

  assign adv = run_en & picked;

endmodule

// File: rtl/btm_counter.sv
module btm_counter
  import btm_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int TAP_N    = 4,
  parameter int TAP_BASE = 4,
  parameter int TAP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt,
  output logic [TAP_N-1:0] tap_fall
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt  = cnt + ONE;
  assign wrap_evt = adv & (&cnt);

  for (genvar k = 0; k < TAP_N; k++) begin : g_tap
    localparam int B = tap_bit(k, TAP_BASE, TAP_STEP);
    assign tap_fall[k] = adv & cnt[B] & ~cnt_nxt[B];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (adv)    cnt <= cnt_nxt;
  end

endmodule

// File: rtl/btm_flags.sv
module btm_flags
  import btm_pkg::*;
#(
  parameter int TAP_N = 4,
  localparam int SEL_W = (TAP_N > 1) ? $clog2(TAP_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wrap_evt,
  input  logic [TAP_N-1:0] tap_fall,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             ovf_ack,
  input  logic             per_ack,
  output logic             ovf_flag,
  output logic             per_flag,
  output logic             per_evt
);

  assign per_evt = tap_fall[tap_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      per_flag <= 1'b0;
    end else if (clr) begin
      ovf_flag <= 1'b0;
      per_flag <= 1'b0;
    end else begin
      ovf_flag <= flag_next(ovf_flag, wrap_evt, ovf_ack);
      per_flag <= flag_next(per_flag, per_evt, per_ack);
    end
  end

endmodule

// File: rtl/base_tick_timer.sv
module base_tick_timer
  import btm_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int TAP_N    = 4,
  parameter int TAP_BASE = 4,
  parameter int TAP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             clr,
  input  logic [1:0]       src_sel,
  input  logic             xtal_stb,
  input  logic             pre_stb,
  input  logic [1:0]       tap_sel,
  input  logic             ovf_ack,
  input  logic             per_ack,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             per_flag
);

  // Internal events, named for the checker.
  logic             adv;
  logic             wrap_evt;
  logic             per_evt;
  logic [TAP_N-1:0] tap_fall;

  btm_src_mux u_mux (
    .run_en   (run_en),
    .src_sel  (src_sel),
    .xtal_stb (xtal_stb),
    .pre_stb  (pre_stb),
    .adv      (adv)
  );

  btm_counter #(
    .CNT_W    (CNT_W),
    .TAP_N    (TAP_N),
    .TAP_BASE (TAP_BASE),
    .TAP_STEP (TAP_STEP)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .adv      (adv),
    .cnt      (count),
    .wrap_evt (wrap_evt),
    .tap_fall (tap_fall)
  );

  btm_flags #(
    .TAP_N (TAP_N)
  ) u_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .wrap_evt (wrap_evt),
    .tap_fall (tap_fall),
    .tap_sel  (tap_sel),
    .ovf_ack  (ovf_ack),
    .per_ack  (per_ack),
    .ovf_flag (ovf_flag),
    .per_flag (per_flag),
    .per_evt  (per_evt)
  );

endmodule

// File: rtl/base_tick_timer_chk.sv
module base_tick_timer_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             clr,
  input logic [1:0]       src_sel,
  input logic             ovf_ack,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             per_flag,
  input logic             adv,
  input logic             wrap_evt,
  input logic             per_evt
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (count == $past(count) + ONE));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr) |=> $stable(count));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !clr) |=> (ovf_flag && count == '0));

  assert_tap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_evt && !clr) |=> per_flag);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !ovf_flag && !per_flag));

  assert_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3 && !clr) |=> $stable(count));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_ack && !clr) |=> ovf_flag);

endmodule

bind base_tick_timer base_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .clr      (clr),
  .src_sel  (src_sel),
  .ovf_ack  (ovf_ack),
  .count    (count),
  .ovf_flag (ovf_flag),
  .per_flag (per_flag),
  .adv      (adv),
  .wrap_evt (wrap_evt),
  .per_evt  (per_evt)
);

// File: tb/base_tick_timer_bench.sv
module base_tick_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, clr = 1'b0, xs = 1'b0, ps = 1'b0, oc = 1'b0, pc = 1'b0;
  logic [1:0]  src = 2'd0, tap = 2'd0;
  logic [13:0] count;
  logic        ovf_flag, per_flag;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  int m_cnt = 0;
  bit m_ovf = 0, m_per = 0;

  always #4 clk = ~clk;

  base_tick_timer u_base_tick_timer (
    .clk(clk), .rst_n(rst_n), .run_en(en), .clr(clr), .src_sel(src),
    .xtal_stb(xs), .pre_stb(ps), .tap_sel(tap), .ovf_ack(oc), .per_ack(pc),
    .count(count), .ovf_flag(ovf_flag), .per_flag(per_flag)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One clock: inputs already applied; model updates at the edge, compare after it.
  task automatic step();
    bit adv, wset, pset;
    int b, nx;
    @(posedge clk);
    cycles++;
    adv = en && ((src == 2'd0 && xs) || src == 2'd1 || (src == 2'd2 && ps));
    if (clr) begin
      m_cnt = 0; m_ovf = 0; m_per = 0;
    end else begin
      b    = 4 + 2 * int'(tap);
      nx   = (m_cnt + 1) % 16384;
      wset = adv && (m_cnt == 16383);
      pset = adv && (((m_cnt >> b) & 1) == 1) && (((nx >> b) & 1) == 0);
      m_ovf = wset || (m_ovf && !oc);
      m_per = pset || (m_per && !pc);
      if (adv) m_cnt = nx;
    end
    @(negedge clk);
    chk(int'(count), m_cnt, "R2 count");
    chk(int'(ovf_flag), int'(m_ovf), "R4 ovf_flag");
    chk(int'(per_flag), int'(m_per), "R5 per_flag");
  endtask

  task automatic idle_inputs();
    en = 0; clr = 0; xs = 0; ps = 0; oc = 0; pc = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(int'(count), 0, "R1 count");
    chk(int'(ovf_flag), 0, "R1 ovf_flag");
    chk(int'(per_flag), 0, "R1 per_flag");
    rst_n = 1;
    @(negedge clk);

    // System-clock source over more than one wrap, rotating taps (R4, R5, R9).
    src = 2'd1; en = 1;
    for (int i = 0; i < 20000; i++) begin
      tap = 2'((i / 4096) % 4);
      oc = ($urandom_range(0, 49) == 0);
      pc = ($urandom_range(0, 49) == 0);
      step();
    end
    idle_inputs();

    // R3: enable low holds the count.
    src = 2'd1; xs = 1; ps = 1;
    held = int'(count);
    repeat (10) step();
    chk(int'(count), held, "R3 hold with enable low");

    // R8: parked source code.
    en = 1; src = 2'd3;
    held = int'(count);
    repeat (10) step();
    chk(int'(count), held, "R8 parked source");

    // Mixed sources (R2, R3, R8).
    for (int i = 0; i < 30000; i++) begin
      xs  = (i % 4 == 0);
      ps  = ($urandom_range(0, 2) == 0);
      en  = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 199) == 0) src = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 499) == 0) tap = 2'($urandom_range(0, 3));
      clr = ($urandom_range(0, 2999) == 0);
      oc  = ($urandom_range(0, 99) == 0);
      pc  = ($urandom_range(0, 99) == 0);
      step();
    end
    idle_inputs();

    // R6: clear on an advancing cycle.
    en = 1; src = 2'd1;
    repeat (5) step();
    clr = 1;
    step();
    clr = 0;
    chk(int'(count), 0, "R6 clear beats advance");

    // R7: acknowledge on the exact wrap cycle; set wins.
    clr = 1; step(); clr = 0;
    repeat (16383) step();
    chk(int'(count), 16383, "R4 count before wrap");
    oc = 1;
    step();
    chk(int'(ovf_flag), 1, "R7 set wins over ack");
    chk(int'(count), 0, "R4 wrap to zero");
    step();
    oc = 0;
    chk(int'(ovf_flag), 0, "R7 ack clears flag");

    idle_inputs();
    step();
    finish_run();
  end

endmodule